// File: doc/BRIEF.md
# QC-LDPC Frame Ingest and Codeword Serializer

This block is the streaming edge of a quasi-cyclic LDPC encoder. It takes a message one bit per cycle, framed by start, end and valid strobes, together with a 2-bit lifting-size selector and a 2-bit rate selector. It captures the selectors on the accepted start cycle and holds them for the rest of the frame. It packs the incoming bits into subblock-wide words in an input store. Once the last word has landed, it pulses an encode enable so that the parity engine can read whole subblocks through a dedicated read port.

When the parity engine reports completion, the block sends the finished codeword as a serial stream. The stored information bits come first, followed by the parity subblocks fetched through a word-read interface. The output carries its own start, end and valid marks. A frame whose end strobe arrives on the wrong bit is discarded and flagged. While a frame is in flight, new frame starts are refused.

Top module: `ldpc_frame_io`

## Requirements
- R1: The selectors are captured on the accepted start cycle, appear on `cfg_len` and `cfg_rate`, and stay unchanged while `busy` is high, whatever the selector inputs do later in the frame.
- R2: The length selector picks the subblock size Z: 0 gives 27, 1 gives 54, and both 2 and 3 give 81. Every codeword spans 24 subblocks, so its length is 648, 1296 or 1944 bits.
- R3: Rate selector values 0, 1, 2 and 3 give rates 1/2, 2/3, 3/4 and 5/6, which is 12, 16, 18 or 20 information subblocks. The information length K is that count times Z.
- R4: Information bit n (counting from 0) is stored in word n/Z at bit position n mod Z. An `alpha_addr` presented in one cycle returns that word on `alpha_word` in the next cycle, while no serialization is running.
- R5: `encode_en` is a single-cycle pulse. It is high in the second cycle after the cycle that carries information bit K, and at no other time.
- R6: `in_end` must accompany bit K exactly. An end strobe on an earlier bit, or bit K arriving without one, sets `len_err` in the following cycle and discards the frame with no `encode_en`. `busy` falls one cycle after that.
- R7: `len_err` stays set until the next accepted frame start clears it.
- R8: The first cycle with `parity_done` high after `encode_en` starts the output. The information bits go out in ascending order, then parity words from address 0 upward, each word bit 0 first, one bit per `out_valid` cycle. `par_word` is sampled one cycle after `par_addr` is presented.
- R9: `out_start` marks the first codeword bit and `out_end` the last. A codeword carries exactly 24×Z valid bits.
- R10: `busy` rises in the cycle after an accepted start and falls in the cycle after `out_end`. `in_start` is ignored while `busy` is high, including during serialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Message bit |
| in_start | input | 1 | First message bit marker |
| in_end | input | 1 | Last message bit marker |
| in_valid | input | 1 | Message bit qualifier |
| len_sel | input | 2 | Lifting-size selector |
| rate_sel | input | 2 | Code rate selector |
| busy | output | 1 | Frame in flight; starts refused |
| len_err | output | 1 | Frame length mismatch flag |
| cfg_len | output | 2 | Captured length selector |
| cfg_rate | output | 2 | Captured rate selector |
| encode_en | output | 1 | Message fully stored pulse |
| alpha_addr | input | 5 | Parity engine read address into the input store |
| alpha_word | output | 81 | Input store word, one cycle after address |
| parity_done | input | 1 | Parity engine finished |
| par_addr | output | 4 | Parity word address |
| par_word | input | 81 | Parity word, one cycle after address |
| out_bit | output | 1 | Codeword bit |
| out_start | output | 1 | First codeword bit marker |
| out_end | output | 1 | Last codeword bit marker |
| out_valid | output | 1 | Codeword bit qualifier |

## Verification
The bound checker watches every cycle for the following: framing marks appearing without valid, output appearing while not busy, an encode pulse that is longer than one cycle or falls outside a frame, and captured configuration that moves during a frame. Only the bench scenarios can show the rest. That covers the bit order across the information/parity boundary, the word packing seen through the alpha port, the exact cycle of `encode_en`, the rejection of early and missing end strobes with the flag clearing on the next frame, and refused starts during the wait for parity and during serialization.

// File: rtl/ldpc_fe_pkg.sv
package ldpc_fe_pkg;
  localparam int BASE_COLS      = 24;
  localparam int LIFT_MAX       = 81;
  localparam int LIFT_W         = $clog2(LIFT_MAX + 1);
  localparam int INFO_WORDS_MAX = 20;
  localparam int PAR_WORDS_MAX  = 12;
  localparam int CNT_W          = $clog2(BASE_COLS + 1);

  function automatic logic [LIFT_W-1:0] lift_of(input logic [1:0] len_idx);
    case (len_idx)
      2'd0:    return LIFT_W'(27);
      2'd1:    return LIFT_W'(54);
      default: return LIFT_W'(81);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] info_words_of(input logic [1:0] rate_idx);
    case (rate_idx)
      2'd0:    return CNT_W'(12);
      2'd1:    return CNT_W'(16);
      2'd2:    return CNT_W'(18);
      default: return CNT_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/ldpc_fe_ram.sv
module ldpc_fe_ram #(
  parameter int WIDTH = 81,
  parameter int DEPTH = 20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ldpc_fe_ingest.sv
module ldpc_fe_ingest
  import ldpc_fe_pkg::*;
#(
  parameter int LMAX = LIFT_MAX,
  parameter int WORDS = INFO_WORDS_MAX,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              allow_start,
  input  logic              in_bit,
  input  logic              in_start,
  input  logic              in_end,
  input  logic              in_valid,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        rate_sel,
  output logic              start_acc,
  output logic [1:0]        cfg_len,
  output logic [1:0]        cfg_rate,
  output logic [LIFT_W-1:0] lift_q,
  output logic [CNT_W-1:0]  iw_q,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [LMAX-1:0]   wr_data,
  output logic              frame_done,
  output logic              abort,
  output logic              len_err
);
  logic              running;
  logic [LIFT_W-1:0] bit_idx, idx_b, cur_lift;
  logic [AW-1:0]     word_idx, idx_w;
  logic [CNT_W-1:0]  cur_iw;
  logic [LMAX-1:0]   asm_q, merged;
  logic              take, word_full, frame_full;

  always_comb begin
    start_acc  = !running && allow_start && in_valid && in_start;
    take       = start_acc || (running && in_valid);
    cur_lift   = start_acc ? lift_of(len_sel) : lift_q;
    cur_iw     = start_acc ? info_words_of(rate_sel) : iw_q;
    idx_b      = start_acc ? '0 : bit_idx;
    idx_w      = start_acc ? '0 : word_idx;
    word_full  = (idx_b == cur_lift - LIFT_W'(1));
    frame_full = word_full && (CNT_W'(idx_w) == cur_iw - CNT_W'(1));
    merged     = start_acc ? '0 : asm_q;
    merged[idx_b] = in_bit;
  end

  always_ff @(posedge clk) begin
    wr_en      <= 1'b0;
    frame_done <= 1'b0;
    abort      <= 1'b0;
    if (rst) begin
      running  <= 1'b0;
      bit_idx  <= '0;
      word_idx <= '0;
      asm_q    <= '0;
      lift_q   <= lift_of(2'd0);
      iw_q     <= info_words_of(2'd0);
      cfg_len  <= 2'd0;
      cfg_rate <= 2'd0;
      len_err  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (start_acc) begin
        cfg_len  <= len_sel;
        cfg_rate <= rate_sel;
        lift_q   <= cur_lift;
        iw_q     <= cur_iw;
        len_err  <= 1'b0;
      end
      if (take) begin
        if (in_end != frame_full) begin
          running <= 1'b0;
          len_err <= 1'b1;
          abort   <= 1'b1;
        end else begin
          running    <= !frame_full;
          asm_q      <= merged;
          frame_done <= frame_full;
          if (word_full) begin
            wr_en    <= 1'b1;
            wr_addr  <= idx_w;
            wr_data  <= merged;
            bit_idx  <= '0;
            word_idx <= idx_w + AW'(1);
          end else begin
            bit_idx  <= idx_b + LIFT_W'(1);
            word_idx <= idx_w;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ldpc_fe_serial.sv
module ldpc_fe_serial
  import ldpc_fe_pkg::*;
#(
  parameter int LMAX = LIFT_MAX,
  parameter int WORDS = INFO_WORDS_MAX,
  parameter int PWORDS = PAR_WORDS_MAX,
  localparam int AW = $clog2(WORDS),
  localparam int PAW = $clog2(PWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [LIFT_W-1:0] lift,
  input  logic [CNT_W-1:0]  info_words,
  input  logic [CNT_W-1:0]  par_words,
  output logic [AW-1:0]     ram_addr,
  input  logic [LMAX-1:0]   ram_data,
  output logic [PAW-1:0]    par_addr,
  input  logic [LMAX-1:0]   par_data,
  output logic              active,
  output logic              out_bit,
  output logic              out_start,
  output logic              out_end,
  output logic              out_valid,
  output logic              done
);
  typedef enum logic [1:0] {SR_IDLE, SR_ADDR, SR_LOAD, SR_SHIFT} sr_state_t;
  sr_state_t         st;
  logic              in_par, first_q, sec_last;
  logic [CNT_W-1:0]  widx;
  logic [LIFT_W-1:0] bidx;
  logic [LMAX-1:0]   sreg;

  assign ram_addr = AW'(widx);
  assign par_addr = PAW'(widx);
  assign active   = (st != SR_IDLE);
  assign sec_last = (widx == (in_par ? par_words : info_words) - CNT_W'(1));

  always_ff @(posedge clk) begin
    out_valid <= 1'b0;
    out_start <= 1'b0;
    out_end   <= 1'b0;
    done      <= 1'b0;
    if (rst) begin
      st      <= SR_IDLE;
      in_par  <= 1'b0;
      first_q <= 1'b0;
      widx    <= '0;
      bidx    <= '0;
      sreg    <= '0;
      out_bit <= 1'b0;
    end else begin
      case (st)
        SR_IDLE: if (go) begin
          in_par  <= 1'b0;
          first_q <= 1'b1;
          widx    <= '0;
          bidx    <= '0;
          st      <= SR_ADDR;
        end
        SR_ADDR: st <= SR_LOAD;
        SR_LOAD: begin
          sreg <= in_par ? par_data : ram_data;
          st   <= SR_SHIFT;
        end
        SR_SHIFT: begin
          out_valid <= 1'b1;
          out_bit   <= sreg[bidx];
          out_start <= first_q;
          first_q   <= 1'b0;
          if (bidx == lift - LIFT_W'(1)) begin
            bidx <= '0;
            if (!sec_last) begin
              widx <= widx + CNT_W'(1);
              st   <= SR_ADDR;
            end else if (!in_par) begin
              in_par <= 1'b1;
              widx   <= '0;
              st     <= SR_ADDR;
            end else begin
              out_end <= 1'b1;
              done    <= 1'b1;
              st      <= SR_IDLE;
            end
          end else begin
            bidx <= bidx + LIFT_W'(1);
          end
        end
        default: st <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_frame_io.sv
module ldpc_frame_io
  import ldpc_fe_pkg::*;
#(
  parameter int LMAX = LIFT_MAX,
  parameter int WORDS = INFO_WORDS_MAX,
  parameter int PWORDS = PAR_WORDS_MAX,
  localparam int AW = $clog2(WORDS),
  localparam int PAW = $clog2(PWORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_bit,
  input  logic            in_start,
  input  logic            in_end,
  input  logic            in_valid,
  input  logic [1:0]      len_sel,
  input  logic [1:0]      rate_sel,
  output logic            busy,
  output logic            len_err,
  output logic [1:0]      cfg_len,
  output logic [1:0]      cfg_rate,
  output logic            encode_en,
  input  logic [AW-1:0]   alpha_addr,
  output logic [LMAX-1:0] alpha_word,
  input  logic            parity_done,
  output logic [PAW-1:0]  par_addr,
  input  logic [LMAX-1:0] par_word,
  output logic            out_bit,
  output logic            out_start,
  output logic            out_end,
  output logic            out_valid
);
  logic              start_acc, frame_done, abort, wr_en, ser_active, ser_done, wait_par;
  logic [LIFT_W-1:0] lift_q;
  logic [CNT_W-1:0]  iw_q, pw;
  logic [AW-1:0]     wr_addr, ser_addr, rd_addr;
  logic [LMAX-1:0]   wr_data, rd_data;

  ldpc_fe_ingest #(.LMAX(LMAX), .WORDS(WORDS)) u_ingest (
    .clk(clk), .rst(rst), .allow_start(!busy),
    .in_bit(in_bit), .in_start(in_start), .in_end(in_end), .in_valid(in_valid),
    .len_sel(len_sel), .rate_sel(rate_sel), .start_acc(start_acc),
    .cfg_len(cfg_len), .cfg_rate(cfg_rate), .lift_q(lift_q), .iw_q(iw_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .abort(abort), .len_err(len_err)
  );

  assign rd_addr    = ser_active ? ser_addr : alpha_addr;
  assign alpha_word = rd_data;
  assign pw         = CNT_W'(BASE_COLS) - iw_q;

  ldpc_fe_ram #(.WIDTH(LMAX), .DEPTH(WORDS)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  ldpc_fe_serial #(.LMAX(LMAX), .WORDS(WORDS), .PWORDS(PWORDS)) u_serial (
    .clk(clk), .rst(rst), .go(wait_par && parity_done),
    .lift(lift_q), .info_words(iw_q), .par_words(pw),
    .ram_addr(ser_addr), .ram_data(rd_data), .par_addr(par_addr), .par_data(par_word),
    .active(ser_active), .out_bit(out_bit), .out_start(out_start), .out_end(out_end),
    .out_valid(out_valid), .done(ser_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      encode_en <= 1'b0;
      wait_par  <= 1'b0;
    end else begin
      encode_en <= frame_done;
      if (start_acc) busy <= 1'b1;
      else if (abort || ser_done) busy <= 1'b0;
      if (encode_en) wait_par <= 1'b1;
      else if (parity_done) wait_par <= 1'b0;
    end
  end
endmodule

// File: rtl/ldpc_frame_io_chk.sv
module ldpc_frame_io_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       encode_en,
  input logic       out_valid,
  input logic       out_start,
  input logic       out_end,
  input logic [1:0] cfg_len,
  input logic [1:0] cfg_rate
);
  assert_marks_need_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (out_start || out_end) |-> out_valid);

  assert_output_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  assert_encode_single_R5: assert property (@(posedge clk) disable iff (rst)
    encode_en |=> !encode_en);

  assert_encode_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    encode_en |-> busy);

  assert_cfg_held_R1: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(cfg_len) && $stable(cfg_rate))));
endmodule

bind ldpc_frame_io ldpc_frame_io_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .encode_en(encode_en), .out_valid(out_valid),
  .out_start(out_start), .out_end(out_end), .cfg_len(cfg_len), .cfg_rate(cfg_rate)
);

// File: tb/ldpc_frame_io_tb.sv
module ldpc_frame_io_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LM = 81;

  logic clk = 1'b0, rst = 1'b1;
  logic in_bit = 1'b0, in_start = 1'b0, in_end = 1'b0, in_valid = 1'b0;
  logic [1:0] len_sel = 2'd0, rate_sel = 2'd0;
  logic busy, len_err, encode_en, parity_done = 1'b0;
  logic [1:0] cfg_len, cfg_rate;
  logic [4:0] alpha_addr = '0;
  logic [LM-1:0] alpha_word, par_word;
  logic [3:0] par_addr;
  logic out_bit, out_start, out_end, out_valid;

  ldpc_frame_io u_dut (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_start(in_start), .in_end(in_end),
    .in_valid(in_valid), .len_sel(len_sel), .rate_sel(rate_sel), .busy(busy),
    .len_err(len_err), .cfg_len(cfg_len), .cfg_rate(cfg_rate), .encode_en(encode_en),
    .alpha_addr(alpha_addr), .alpha_word(alpha_word), .parity_done(parity_done),
    .par_addr(par_addr), .par_word(par_word), .out_bit(out_bit), .out_start(out_start),
    .out_end(out_end), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, out_count = 0;
  typedef struct packed { logic b; logic first; logic last; } exp_t;
  exp_t exp_q[$];
  exp_t e;
  logic [LM-1:0] pmem [16];
  bit info_bits [2048];

  always @(posedge clk) par_word <= pmem[par_addr];

  function automatic int lift_tb(input logic [1:0] li);
    return (li == 2'd0) ? 27 : (li == 2'd1) ? 54 : 81;
  endfunction
  function automatic int blocks_tb(input logic [1:0] ri);
    return (ri == 2'd0) ? 12 : (ri == 2'd1) ? 16 : (ri == 2'd2) ? 18 : 20;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Scoreboard monitor: every valid output bit is compared against the queue (R8, R9)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      out_count++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected output bit: actual 1 expected 0");
      end else begin
        e = exp_q.pop_front();
        if (out_bit !== e.b || out_start !== e.first || out_end !== e.last) begin
          errors++;
          $display("FAIL R8 R9 bit/start/end: actual %0b%0b%0b expected %0b%0b%0b",
                   out_bit, out_start, out_end, e.b, e.first, e.last);
        end
      end
    end
  end

  // mode 0: well formed, 1: end strobe five bits early, 2: no end strobe on bit K
  task automatic drive_frame(input logic [1:0] li, input logic [1:0] ri, input int mode);
    int k = blocks_tb(ri) * lift_tb(li);
    int stop = (mode == 1) ? k - 5 : k;
    for (int n = 0; n < stop; n++) begin
      @(negedge clk);
      if (n == 1) chk(len_err == 1'b0, "R7", "len_err after accepted start", len_err, 0);
      in_valid = 1'b1;
      in_bit   = 1'($urandom);
      in_start = (n == 0);
      in_end   = (n == stop - 1) && (mode != 2);
      len_sel  = (n == 0) ? li : ~li;
      rate_sel = (n == 0) ? ri : ~ri;
      info_bits[n] = in_bit;
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
  endtask

  task automatic pulse_start();
    in_valid = 1'b1; in_start = 1'b1; in_end = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
  endtask

  task automatic run_good(input logic [1:0] li, input logic [1:0] ri);
    int z = lift_tb(li);
    int nb = blocks_tb(ri);
    int k = nb * z;
    int pw = 24 - nb;
    int guard;
    logic [LM-1:0] w;
    drive_frame(li, ri, 0);
    chk(encode_en == 1'b0, "R5", "encode_en one cycle after last bit", encode_en, 0);
    @(negedge clk);
    chk(encode_en == 1'b1, "R5 R3", "encode_en two cycles after bit K", encode_en, 1);
    chk(cfg_len == li, "R1", "captured length selector", cfg_len, li);
    chk(cfg_rate == ri, "R1", "captured rate selector", cfg_rate, ri);
    chk(busy == 1'b1, "R10", "busy during frame", busy, 1);
    for (int wd = 0; wd < nb; wd++) begin
      alpha_addr = 5'(wd);
      @(negedge clk);
      if (wd == 0) chk(encode_en == 1'b0, "R5", "encode_en single cycle", encode_en, 0);
      w = '0;
      for (int j = 0; j < z; j++) w[j] = info_bits[wd*z + j];
      for (int j = z; j < LM; j++) w[j] = alpha_word[j];
      chk(alpha_word == w, "R4", "stored subblock word", wd, wd);
    end
    // start while waiting for parity must be ignored
    pulse_start();
    @(negedge clk);
    chk(len_err == 1'b0 && busy == 1'b1, "R10", "start refused while waiting", {len_err, busy}, 1);
    for (int p = 0; p < 16; p++) pmem[p] = {$urandom, $urandom, $urandom};
    for (int n = 0; n < k; n++) exp_q.push_back('{b: info_bits[n], first: (n == 0), last: 1'b0});
    for (int p = 0; p < pw; p++)
      for (int j = 0; j < z; j++)
        exp_q.push_back('{b: pmem[p][j], first: 1'b0, last: (p == pw-1) && (j == z-1)});
    out_count = 0;
    parity_done = 1'b1;
    @(negedge clk);
    parity_done = 1'b0;
    guard = 0;
    while (busy && guard < 6000) begin
      if (guard == 200) pulse_start(); else @(negedge clk);
      guard++;
    end
    chk(busy == 1'b0, "R10", "busy released after codeword", busy, 0);
    chk(exp_q.size() == 0, "R9", "bits left unsent", exp_q.size(), 0);
    chk(out_count == 24 * z, "R2", "codeword length", out_count, 24 * z);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && len_err == 1'b0, "R10", "refused starts left no trace", {out_valid, len_err}, 0);
  endtask

  task automatic run_bad(input logic [1:0] li, input logic [1:0] ri, input int mode);
    bit seen = 1'b0;
    drive_frame(li, ri, mode);
    chk(len_err == 1'b1, "R6", "len_err after bad end", len_err, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R6", "busy released after bad frame", busy, 0);
    for (int c = 0; c < 10; c++) begin
      if (encode_en) seen = 1'b1;
      @(negedge clk);
    end
    chk(seen == 1'b0, "R6", "no encode for bad frame", seen, 0);
    chk(len_err == 1'b1, "R7", "len_err held", len_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && encode_en == 0 && out_valid == 0 && len_err == 0, "R10",
        "reset state", {busy, encode_en, out_valid, len_err}, 0);
    run_good(2'd0, 2'd0);
    run_good(2'd1, 2'd1);
    run_good(2'd2, 2'd3);
    run_bad(2'd2, 2'd0, 1);
    run_good(2'd3, 2'd2);
    run_bad(2'd0, 2'd3, 2);
    run_good(2'd0, 2'd1);
    finish_run();
  end
endmodule